// File: doc/BRIEF.md
# Dual-Lane Interleaved Montgomery Multiplier

This block computes the Montgomery product C = A·B·2^(-32n) mod M of three n-limb operands (32-bit limbs) and a precomputed 32-bit reduction constant. The caller presents A, B, M and the constant in parallel and pulses `start`. The block latches them and processes A one limb per outer iteration, least significant limb first. When the fully reduced result is ready, it pulses `done` and holds the result on `c_out`.

Each iteration first forms a quotient digit from the lowest limbs only. It then runs two independent limb-serial product streams, one for a_i·B and one for q·M, each into its own accumulator. Each accumulator drops one limb per iteration. After the last iteration, the signed difference of the two accumulators is brought into [0, M) with a single add or subtract of M.

Top module: `mm_dual_lane`

## Requirements
- R1: With M odd, A < M, B < M and `mu_in` = +M^(-1) mod 2^32 (the positive inverse, so M·mu ≡ 1 mod 2^32), `c_out` at `done` equals A·B·2^(-32·NLIMB) mod M.
- R2: Every result presented with `done` satisfies 0 ≤ `c_out` < M.
- R3: `done` is a one-cycle pulse. The pulse appears NLIMB·(NLIMB+2)+1 clock cycles after the edge that samples `start` in the idle state. `busy` is high from the cycle after that edge until `done` rises, and `busy` is low while `done` is high.
- R4: A `start` pulse while `busy` is high is ignored. It changes neither the result nor the cycle at which `done` arrives.
- R5: Operands are captured at the accepted `start`. Changes to `a_in`, `b_in`, `m_in` or `mu_in` during the operation do not alter the result.
- R6: After reset, `busy` = 0, `done` = 0 and `c_out` = 0.
- R7: If A = 0 or B = 0, the result is 0.
- R8: `c_out` changes only on the cycle in which `done` is high, and it holds its value between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (sampled while idle) |
| a_in | input | NLIMB*LIMB_W | Operand A, limb 0 in the low bits |
| b_in | input | NLIMB*LIMB_W | Operand B |
| m_in | input | NLIMB*LIMB_W | Odd modulus M |
| mu_in | input | LIMB_W | +M^(-1) mod 2^LIMB_W |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| c_out | output | NLIMB*LIMB_W | Montgomery product |

## Verification
Random odd 128-bit moduli with random operands below them check the arithmetic broadly. Zero operands check that both lanes cancel exactly, and A = B = M−1 pushes both accumulators to their largest values. The smallest modulus 3 and the all-ones modulus stress the final sign and range correction from both ends. A run in which the inputs are scrambled and `start` is re-pulsed mid-operation separates true operand latching and idle-only acceptance from a design that re-samples its inputs.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_QDIG = 2'd1,
    ST_LANE = 2'd2,
    ST_FIX  = 2'd3
  } mm_state_e;
endpackage

// File: rtl/mm_lane.sv
// One limb step of a product stream: acc + x*y + carry, split into low/high limbs.
module mm_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mul_x,
  input  logic [W-1:0] mul_y,
  input  logic [W-1:0] cin,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [2*W-1:0] prod;
  logic [2*W-1:0] sum;

  always_comb begin
    prod = {{W{1'b0}}, mul_x} * {{W{1'b0}}, mul_y};
    sum  = prod + {{W{1'b0}}, acc} + {{W{1'b0}}, cin};
    lo   = sum[W-1:0];
    hi   = sum[2*W-1:W];
  end
endmodule

// File: rtl/mm_qdigit.sv
// Quotient digit from the lowest limbs: q = ((y0 - z0) + a*b0) * mu mod 2^W.
module mm_qdigit #(
  parameter int W = 32
) (
  input  logic [W-1:0] y0,
  input  logic [W-1:0] z0,
  input  logic [W-1:0] a_limb,
  input  logic [W-1:0] b0,
  input  logic [W-1:0] mu,
  output logic [W-1:0] q
);
  logic [W-1:0]   c0;
  logic [2*W-1:0] ab;
  logic [W-1:0]   s;
  logic [2*W-1:0] p;

  always_comb begin
    c0 = y0 - z0;
    ab = {{W{1'b0}}, a_limb} * {{W{1'b0}}, b0};
    s  = c0 + ab[W-1:0];
    p  = {{W{1'b0}}, s} * {{W{1'b0}}, mu};
    q  = p[W-1:0];
  end
endmodule

// File: rtl/mm_fix.sv
// Signed lane difference brought into [0, M) with one add or subtract.
module mm_fix #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic [(N+1)*W-1:0] y,
  input  logic [(N+1)*W-1:0] z,
  input  logic [N*W-1:0]     m,
  output logic [N*W-1:0]     res
);
  localparam int DW = (N+1)*W+1;

  logic [DW-1:0] d;
  logic [DW-1:0] mx;
  logic [DW-1:0] d_add;
  logic [DW-1:0] d_sub;
  logic          neg;
  logic          ge;

  always_comb begin
    d     = {1'b0, y} - {1'b0, z};
    mx    = {{(W+1){1'b0}}, m};
    neg   = d[DW-1];
    d_add = d + mx;
    d_sub = d - mx;
    ge    = !neg && (d >= mx);
    if (neg)     res = d_add[N*W-1:0];
    else if (ge) res = d_sub[N*W-1:0];
    else         res = d[N*W-1:0];
  end
endmodule

// File: rtl/mm_dual_lane.sv
module mm_dual_lane
  import mm_pkg::*;
#(
  parameter int LIMB_W = 32,
  parameter int NLIMB  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NLIMB*LIMB_W-1:0]   a_in,
  input  logic [NLIMB*LIMB_W-1:0]   b_in,
  input  logic [NLIMB*LIMB_W-1:0]   m_in,
  input  logic [LIMB_W-1:0]         mu_in,
  output logic                      busy,
  output logic                      done,
  output logic [NLIMB*LIMB_W-1:0]   c_out
);
  localparam int VW = NLIMB*LIMB_W;
  localparam int CW = $clog2(NLIMB+1);
  localparam logic [CW-1:0] J_LAST = CW'(NLIMB);
  localparam logic [CW-1:0] I_LAST = CW'(NLIMB-1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_m} <= 2'b00;
    else        {rst_s, rst_m} <= {rst_m, 1'b1};
  end

  mm_state_e          st_q, st_d;
  logic [CW-1:0]      i_q, i_d, j_q, j_d;
  logic [VW-1:0]      a_q, b_q, m_q, c_q;
  logic [LIMB_W-1:0]  mu_q, q_q, q_d;
  logic [LIMB_W-1:0]  cy_y_q, cy_z_q;
  logic [LIMB_W-1:0]  y_q [NLIMB+1];
  logic [LIMB_W-1:0]  z_q [NLIMB+1];
  logic               done_q;

  logic ld_en, q_en, lane_en, fix_en;

  // control next state
  always_comb begin
    st_d = st_q;
    i_d  = i_q;
    j_d  = j_q;
    case (st_q)
      ST_IDLE: if (start) begin st_d = ST_QDIG; i_d = '0; end
      ST_QDIG: begin st_d = ST_LANE; j_d = '0; end
      ST_LANE: begin
        if (j_q == J_LAST) begin
          if (i_q == I_LAST) st_d = ST_FIX;
          else begin st_d = ST_QDIG; i_d = i_q + 1'b1; end
        end else begin
          j_d = j_q + 1'b1;
        end
      end
      ST_FIX:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ld_en   = (st_q == ST_IDLE) && start;
    q_en    = (st_q == ST_QDIG);
    lane_en = (st_q == ST_LANE);
    fix_en  = (st_q == ST_FIX);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE;
      i_q  <= '0;
      j_q  <= '0;
    end else begin
      st_q <= st_d;
      i_q  <= i_d;
      j_q  <= j_d;
    end
  end

  // limb selection
  logic [LIMB_W-1:0] a_limb, b_limb, m_limb;
  logic [CW-1:0]     v_idx;
  always_comb begin
    v_idx  = (j_q == J_LAST) ? '0 : j_q;
    a_limb = a_q[i_q*LIMB_W +: LIMB_W];
    b_limb = (j_q == J_LAST) ? '0 : b_q[v_idx*LIMB_W +: LIMB_W];
    m_limb = (j_q == J_LAST) ? '0 : m_q[v_idx*LIMB_W +: LIMB_W];
  end

  mm_qdigit #(.W(LIMB_W)) u_qdigit (
    .y0(y_q[0]), .z0(z_q[0]), .a_limb(a_limb),
    .b0(b_q[LIMB_W-1:0]), .mu(mu_q), .q(q_d)
  );

  logic [LIMB_W-1:0] y_lo, y_hi, z_lo, z_hi;

  mm_lane #(.W(LIMB_W)) u_lane_ab (
    .acc(y_q[j_q]), .mul_x(a_limb), .mul_y(b_limb), .cin(cy_y_q),
    .lo(y_lo), .hi(y_hi)
  );

  mm_lane #(.W(LIMB_W)) u_lane_qm (
    .acc(z_q[j_q]), .mul_x(q_q), .mul_y(m_limb), .cin(cy_z_q),
    .lo(z_lo), .hi(z_hi)
  );

  logic [(NLIMB+1)*LIMB_W-1:0] y_flat, z_flat;
  for (genvar g = 0; g <= NLIMB; g++) begin : g_flat
    assign y_flat[g*LIMB_W +: LIMB_W] = y_q[g];
    assign z_flat[g*LIMB_W +: LIMB_W] = z_q[g];
  end

  logic [VW-1:0] fix_res;
  mm_fix #(.W(LIMB_W), .N(NLIMB)) u_fix (
    .y(y_flat), .z(z_flat), .m(m_q), .res(fix_res)
  );

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q    <= '0;
      b_q    <= '0;
      m_q    <= '0;
      mu_q   <= '0;
      q_q    <= '0;
      cy_y_q <= '0;
      cy_z_q <= '0;
      c_q    <= '0;
      done_q <= 1'b0;
      for (int k = 0; k <= NLIMB; k++) begin
        y_q[k] <= '0;
        z_q[k] <= '0;
      end
    end else begin
      if (ld_en) begin
        a_q  <= a_in;
        b_q  <= b_in;
        m_q  <= m_in;
        mu_q <= mu_in;
        for (int k = 0; k <= NLIMB; k++) begin
          y_q[k] <= '0;
          z_q[k] <= '0;
        end
      end
      if (q_en) begin
        q_q    <= q_d;
        cy_y_q <= '0;
        cy_z_q <= '0;
      end
      if (lane_en) begin
        cy_y_q <= y_hi;
        cy_z_q <= z_hi;
        if (j_q != '0) begin
          y_q[j_q - 1'b1] <= y_lo;
          z_q[j_q - 1'b1] <= z_lo;
        end
        if (j_q == J_LAST) begin
          y_q[NLIMB] <= y_hi;
          z_q[NLIMB] <= z_hi;
        end
      end
      if (fix_en) c_q <= fix_res;
      done_q <= fix_en;
    end
  end

  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign c_out = c_q;
endmodule

// File: rtl/mm_dual_lane_chk.sv
module mm_dual_lane_chk #(
  parameter int LIMB_W = 32,
  parameter int NLIMB  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [NLIMB*LIMB_W-1:0] c_out,
  input logic [NLIMB*LIMB_W-1:0] m_q,
  input logic [NLIMB*LIMB_W-1:0] a_q
);
  localparam logic [15:0] LAT = 16'(NLIMB*(NLIMB+2)+1);

  logic [15:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start && !busy) cnt <= '0;
    else if (busy)           cnt <= cnt + 16'd1;
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_latency_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt == LAT);
  assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> c_out < m_q);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(c_out) |-> done);
  assert_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(m_q)));
endmodule

bind mm_dual_lane mm_dual_lane_chk #(.LIMB_W(LIMB_W), .NLIMB(NLIMB)) u_chk (
  .clk(clk), .rst_n(rst_s), .start(start), .busy(busy), .done(done),
  .c_out(c_out), .m_q(m_q), .a_q(a_q)
);

// File: tb/test_mm_dual_lane.sv
module test_mm_dual_lane;
  localparam int LW  = 32;
  localparam int NL  = 4;
  localparam int VW  = LW*NL;
  localparam int LAT = NL*(NL+2)+1;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [VW-1:0] a_in, b_in, m_in;
  logic [LW-1:0] mu_in;
  logic          busy, done;
  logic [VW-1:0] c_out;

  int total = 0;
  int bad   = 0;

  mm_dual_lane #(.LIMB_W(LW), .NLIMB(NL)) i_mm_dual_lane (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .m_in(m_in), .mu_in(mu_in), .busy(busy), .done(done), .c_out(c_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] inv32(input logic [LW-1:0] m0);
    logic [LW-1:0] x;
    x = m0;
    for (int k = 0; k < 5; k++) x = x * (32'd2 - m0 * x);
    return x;
  endfunction

  // halving reduction: add M when odd, then divide by 2, VW times
  function automatic logic [VW-1:0] mont_ref(input logic [VW-1:0] a, b, m);
    logic [2*VW+3:0] x;
    x = {{(VW+4){1'b0}}, a} * {{(VW+4){1'b0}}, b};
    for (int k = 0; k < VW; k++) begin
      if (x[0]) x = x + {{(VW+4){1'b0}}, m};
      x = x >> 1;
    end
    while (x >= {{(VW+4){1'b0}}, m}) x = x - {{(VW+4){1'b0}}, m};
    return x[VW-1:0];
  endfunction

  task automatic run_op(input logic [VW-1:0] a, b, m, input bit poke,
                        output logic [VW-1:0] res, output int lat);
    @(negedge clk);
    a_in = a; b_in = b; m_in = m; mu_in = inv32(m[LW-1:0]); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
      if (poke && !done) begin
        if (lat == 5) begin
          a_in = ~a; b_in = ~b; m_in = m ^ {{(VW-2){1'b1}}, 2'b00}; mu_in = ~mu_in;
          start = 1'b1;
        end else begin
          start = 1'b0;
        end
      end
    end
    start = 1'b0;
    res = c_out;
    check(!busy, "R3 busy low with done", {{(VW-1){1'b0}}, busy}, '0);
    @(negedge clk);
    check(!done, "R3 done one cycle", {{(VW-1){1'b0}}, done}, '0);
  endtask

  task automatic do_case(input logic [VW-1:0] a, b, m, input bit poke, input string tag);
    logic [VW-1:0] r, e;
    int lat;
    e = mont_ref(a, b, m);
    run_op(a, b, m, poke, r, lat);
    check(r == e, {tag, " R1 value"}, r, e);
    check(r < m, "R2 range", r, m);
    check(lat == LAT, "R3 latency", VW'(lat), VW'(LAT));
  endtask

  initial begin
    #(8*200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [VW-1:0] m, a, b, r1, e1;
    int lat;
    process::self().srandom(32'h5eed_1234);
    start = 1'b0; a_in = '0; b_in = '0; m_in = '0; mu_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    check(!busy && !done, "R6 reset flags", {{(VW-2){1'b0}}, busy, done}, '0);
    check(c_out == '0, "R6 reset result", c_out, '0);

    // directed corners
    m = {$urandom, $urandom, $urandom, $urandom} | {1'b1, {(VW-2){1'b0}}, 1'b1};
    a = {$urandom, $urandom, $urandom, $urandom} % m;
    b = {$urandom, $urandom, $urandom, $urandom} % m;
    do_case('0, b, m, 1'b0, "R7 A=0");
    check(c_out == '0, "R7 zero A", c_out, '0);
    do_case(a, '0, m, 1'b0, "R7 B=0");
    check(c_out == '0, "R7 zero B", c_out, '0);
    do_case(m - 1, m - 1, m, 1'b0, "max operands");
    do_case(m - 1, b, m, 1'b0, "A=M-1");
    do_case(a, m - 1, m, 1'b0, "B=M-1");
    do_case(128'd2, 128'd1, 128'd3, 1'b0, "M=3");
    do_case({VW{1'b1}} - 1, {VW{1'b1}} - 2, {VW{1'b1}}, 1'b0, "M all ones");
    do_case(128'd1, 128'd1, m, 1'b0, "unit");

    // R4/R5: scramble inputs and re-pulse start mid-run
    e1 = mont_ref(a, b, m);
    run_op(a, b, m, 1'b1, r1, lat);
    check(r1 == e1, "R5 latched operands", r1, e1);
    check(lat == LAT, "R4 busy start ignored", VW'(lat), VW'(LAT));

    // R8 result holds while idle with changing inputs
    a_in = ~a_in; b_in = ~b_in;
    repeat (6) @(negedge clk);
    check(c_out == r1, "R8 hold", c_out, r1);
    check(!busy, "R4 no spurious start", {{(VW-1){1'b0}}, busy}, '0);

    // random odd moduli
    for (int t = 0; t < 60; t++) begin
      m = {$urandom, $urandom, $urandom, $urandom} | 128'd1;
      if (t % 3 == 0) m = m >> ($urandom % 100);
      m = m | 128'd1;
      if (m < 3) m = 128'd3;
      a = {$urandom, $urandom, $urandom, $urandom} % m;
      b = {$urandom, $urandom, $urandom, $urandom} % m;
      do_case(a, b, m, (t % 10 == 7), "random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule